// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Refresh

This controller sits between a processor-side request port and a single-bank DRAM whose address pins carry the row and the column one after the other. Each accepted request is one word, read or write. The controller places the row on the shared address pins and pulls the row strobe low. After a programmable delay it places the column and pulls the column strobe low. A write drives the data bus during the column phase. A read captures the data bus on the last cycle of the column strobe.

After an access the row strobe stays low, so the row remains open as a page. A later request to the same row needs only a new column strobe. A request to a different row first raises the row strobe for a precharge time and then opens the new row.

A timer raises a refresh need about every 15.625 µs, with the cycle count derived from the clock frequency parameter. The refresh waits until any access in progress has completed. It closes an open page if there is one. It then strobes only the row strobe, with the next row from a wrapping counter, and leaves the controller idle with no page open.

Top module: `pgdram_ctrl`

## Requirements
- R1: During and right after reset, both strobes are high (inactive, active-low encoding), `req_ready` is high, `rsp_valid` is low and no page is open.
- R2: A request address is `{row, column}`, with the row in the upper ROW_W bits. An access with no page open drives the row on `dram_addr` as the row strobe falls, then the column as the column strobe falls T_RCD cycles later. `rsp_valid` rises T_RCD+T_CAS cycles after the accepting edge.
- R3: An access to the row of the open page causes no row-strobe edge. It strobes only the column, and `rsp_valid` rises T_CAS cycles after the accepting edge.
- R4: An access to a different row than the open page raises the row strobe for T_PRE cycles and then opens the new row, with one row-strobe fall. `rsp_valid` rises T_PRE+T_RCD+T_CAS cycles after acceptance.
- R5: The column strobe stays low for exactly T_CAS cycles per access. `rsp_valid` is a one-cycle pulse, and `rsp_rdata` holds the data sampled on the last column-strobe cycle.
- R6: During the column phase of a write, `dram_we_n` is low and `dram_dq_oe` is high with the write data. During a read, `dram_we_n` is high and `dram_dq_oe` is low. A read returns the last value written to that address.
- R7: Refreshes recur every CLK_MHZ*15625/1000 cycles, apart from a deferral of at most one access and one precharge.
- R8: Each refresh strobes the next row from a counter that starts at 0 and wraps modulo 2^ROW_W.
- R9: A refresh never starts while an access is in progress, and the column strobe stays high throughout it. A pending refresh wins over a request that arrives in the same idle cycle.
- R10: After a refresh no page is open, so the next access takes the R2 path even when it hits the previous row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address {row, column} |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Write data to DRAM |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | DATA_W | Read data from DRAM |

## Verification
The assertions assume the requester holds at most one request outstanding, keeping `req_valid` and its fields stable only until acceptance. They also assume the timing parameters are all at least one. The stimulus issues one access at a time and waits for `rsp_valid` before the next. It draws rows from a small set so that page hits, page misses and closed-page accesses all occur often. It inserts random and long idle gaps so that refreshes start both from idle and from an open page.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_OPEN = 3'd1,
        ST_PRE  = 3'd2,
        ST_ACT  = 3'd3,
        ST_COL  = 3'd4,
        ST_RPRE = 3'd5,
        ST_RACT = 3'd6,
        ST_RREC = 3'd7
    } seq_state_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pgdram_ref_timer.sv
module pgdram_ref_timer #(
    parameter int unsigned REF_CYC = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic pend_o
);
    localparam int unsigned CW = $clog2(REF_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clr_i) begin
            tmr_d.pend = 1'b0;
        end
        if (tmr_q.cnt == CW'(REF_CYC - 1)) begin
            tmr_d.cnt  = '0;
            tmr_d.pend = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pend_o = tmr_q.pend;

    // R9: the sequencer only acknowledges a refresh that is actually pending
    p_clr_only_when_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> pend_o);

endmodule

// File: rtl/pgdram_seq.sv
module pgdram_seq
    import pgdram_pkg::*;
#(
    parameter int unsigned ROW_W  = 8,
    parameter int unsigned COL_W  = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned T_PRE  = 2,
    parameter int unsigned T_RCD  = 2,
    parameter int unsigned T_CAS  = 2,
    parameter int unsigned T_RAS  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_we,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    input  logic                     ref_pend_i,
    output logic                     ref_clr_o,
    output logic [max2(ROW_W,COL_W)-1:0] dram_addr,
    output logic                     dram_ras_n,
    output logic                     dram_cas_n,
    output logic                     dram_we_n,
    output logic [DATA_W-1:0]        dram_dq_out,
    output logic                     dram_dq_oe,
    input  logic [DATA_W-1:0]        dram_dq_in
);
    localparam int unsigned DA_W  = max2(ROW_W, COL_W);
    localparam int unsigned T_MAX = max2(max2(T_PRE, T_RCD), max2(T_CAS, T_RAS));
    localparam int unsigned CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              page_open;
        logic [ROW_W-1:0]  open_row;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rsp;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe;
        logic [DATA_W-1:0] dq;
        logic [DATA_W-1:0] dq_keep;
        logic [DA_W-1:0]   addr;
        logic [ROW_W-1:0]  ref_row;
    } seq_t;

    seq_t s_d, s_q;

    logic             idle_like;
    logic             accept;
    logic [ROW_W-1:0] in_row;
    logic [COL_W-1:0] in_col;
    logic             clr;

    assign idle_like = (s_q.st == ST_IDLE) || (s_q.st == ST_OPEN);
    assign req_ready = idle_like && !ref_pend_i;
    assign accept    = req_valid && req_ready;
    assign in_row    = req_addr[ROW_W+COL_W-1:COL_W];
    assign in_col    = req_addr[COL_W-1:0];

    always_comb begin
        s_d     = s_q;
        s_d.rsp = 1'b0;
        clr     = 1'b0;
        unique case (s_q.st)
            ST_IDLE, ST_OPEN: begin
                if (ref_pend_i) begin
                    if (s_q.st == ST_OPEN) begin
                        s_d.st        = ST_RPRE;
                        s_d.cnt       = CNT_W'(T_PRE);
                        s_d.ras_n     = 1'b1;
                        s_d.page_open = 1'b0;
                    end else begin
                        s_d.st      = ST_RACT;
                        s_d.cnt     = CNT_W'(T_RAS);
                        s_d.ras_n   = 1'b0;
                        s_d.addr    = DA_W'(s_q.ref_row);
                        s_d.ref_row = s_q.ref_row + 1'b1;
                        clr         = 1'b1;
                    end
                end else if (accept) begin
                    s_d.row   = in_row;
                    s_d.col   = in_col;
                    s_d.we    = req_we;
                    s_d.wdata = req_wdata;
                    if (s_q.page_open && (in_row == s_q.open_row)) begin
                        s_d.st    = ST_COL;
                        s_d.cnt   = CNT_W'(T_CAS);
                        s_d.addr  = DA_W'(in_col);
                        s_d.cas_n = 1'b0;
                        s_d.we_n  = !req_we;
                        s_d.oe    = req_we;
                        s_d.dq    = req_wdata;
                    end else if (s_q.page_open) begin
                        s_d.st        = ST_PRE;
                        s_d.cnt       = CNT_W'(T_PRE);
                        s_d.ras_n     = 1'b1;
                        s_d.page_open = 1'b0;
                    end else begin
                        s_d.st       = ST_ACT;
                        s_d.cnt      = CNT_W'(T_RCD);
                        s_d.ras_n    = 1'b0;
                        s_d.addr     = DA_W'(in_row);
                        s_d.open_row = in_row;
                    end
                end
            end
            ST_PRE: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.st       = ST_ACT;
                    s_d.cnt      = CNT_W'(T_RCD);
                    s_d.ras_n    = 1'b0;
                    s_d.addr     = DA_W'(s_q.row);
                    s_d.open_row = s_q.row;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_ACT: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.st    = ST_COL;
                    s_d.cnt   = CNT_W'(T_CAS);
                    s_d.addr  = DA_W'(s_q.col);
                    s_d.cas_n = 1'b0;
                    s_d.we_n  = !s_q.we;
                    s_d.oe    = s_q.we;
                    s_d.dq    = s_q.wdata;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.st        = ST_OPEN;
                    s_d.cas_n     = 1'b1;
                    s_d.we_n      = 1'b1;
                    s_d.oe        = 1'b0;
                    s_d.page_open = 1'b1;
                    s_d.rsp       = 1'b1;
                    if (!s_q.we) begin
                        s_d.rdata = dram_dq_in;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RPRE: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.st      = ST_RACT;
                    s_d.cnt     = CNT_W'(T_RAS);
                    s_d.ras_n   = 1'b0;
                    s_d.addr    = DA_W'(s_q.ref_row);
                    s_d.ref_row = s_q.ref_row + 1'b1;
                    clr         = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RACT: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.st    = ST_RREC;
                    s_d.cnt   = CNT_W'(T_PRE);
                    s_d.ras_n = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RREC: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
            s_q.ras_n <= 1'b1;
            s_q.cas_n <= 1'b1;
            s_q.we_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ref_clr_o   = clr;
    assign rsp_valid   = s_q.rsp;
    assign rsp_rdata   = s_q.rdata;
    assign dram_addr   = s_q.addr;
    assign dram_ras_n  = s_q.ras_n;
    assign dram_cas_n  = s_q.cas_n;
    assign dram_we_n   = s_q.we_n;
    assign dram_dq_out = s_q.dq;
    assign dram_dq_oe  = s_q.oe;

    // R2: a column strobe only happens inside an open row
    p_col_inside_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R3: the column strobe falls only when the row strobe was already low
    p_col_after_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $past(!dram_ras_n));

    // R5: completion is a single-cycle pulse
    p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6: the data bus is driven only with the write enable during a column strobe
    p_drive_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && !dram_cas_n));

    // R8: the refresh row counter only ever steps by one
    p_ref_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.ref_row) |-> (s_q.ref_row == $past(s_q.ref_row) + 1'b1));

    // R9: a refresh in progress never raises a column strobe nor accepts work
    p_ref_no_col_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st inside {ST_RPRE, ST_RACT, ST_RREC}) |-> (dram_cas_n && !req_ready));

    // R10: completing a refresh leaves no page open
    p_ref_closes_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE) |-> !s_q.page_open);

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
    import pgdram_pkg::*;
#(
    parameter int unsigned CLK_MHZ = 100,
    parameter int unsigned ROW_W   = 8,
    parameter int unsigned COL_W   = 8,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned T_PRE   = 2,
    parameter int unsigned T_RCD   = 2,
    parameter int unsigned T_CAS   = 2,
    parameter int unsigned T_RAS   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_we,
    input  logic [ROW_W+COL_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         rsp_valid,
    output logic [DATA_W-1:0]            rsp_rdata,
    output logic [max2(ROW_W,COL_W)-1:0] dram_addr,
    output logic                         dram_ras_n,
    output logic                         dram_cas_n,
    output logic                         dram_we_n,
    output logic [DATA_W-1:0]            dram_dq_out,
    output logic                         dram_dq_oe,
    input  logic [DATA_W-1:0]            dram_dq_in
);
    localparam int unsigned REF_CYC = (CLK_MHZ * 15625) / 1000;

    logic ref_pend;
    logic ref_clr;

    pgdram_ref_timer #(.REF_CYC(REF_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ref_clr),
        .pend_o (ref_pend)
    );

    pgdram_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_PRE(T_PRE), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .ref_pend_i (ref_pend),
        .ref_clr_o  (ref_clr),
        .dram_addr  (dram_addr),
        .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n),
        .dram_we_n  (dram_we_n),
        .dram_dq_out(dram_dq_out),
        .dram_dq_oe (dram_dq_oe),
        .dram_dq_in (dram_dq_in)
    );

endmodule

// File: tb/pgdram_ctrl_tb_top.sv
module pgdram_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ = 8;
    localparam int ROW_W = 6;
    localparam int COL_W = 5;
    localparam int DATA_W = 16;
    localparam int T_PRE = 2;
    localparam int T_RCD = 2;
    localparam int T_CAS = 2;
    localparam int T_RAS = 3;
    localparam int AW = ROW_W + COL_W;
    localparam int DA_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int REF_CYC = (CLK_MHZ * 15625) / 1000;
    localparam int WORDS = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic [DA_W-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [DATA_W-1:0] dram_dq_out;
    logic [DATA_W-1:0] dram_dq_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgdram_ctrl #(
        .CLK_MHZ(CLK_MHZ), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_PRE(T_PRE), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    // simple DRAM model
    logic [DATA_W-1:0] dmem [WORDS];
    logic [DATA_W-1:0] shadow [WORDS];
    logic [ROW_W-1:0] m_row = '0;
    logic [COL_W-1:0] m_col = '0;
    logic m_prev_ras = 1'b1;
    logic m_prev_cas = 1'b1;

    assign dram_dq_in = dmem[{m_row, m_col}];

    always @(negedge clk) begin
        if (m_prev_ras && !dram_ras_n) m_row = dram_addr[ROW_W-1:0];
        if (m_prev_cas && !dram_cas_n) m_col = dram_addr[COL_W-1:0];
        if (!dram_cas_n && !dram_we_n && dram_dq_oe) dmem[{m_row, m_col}] = dram_dq_out;
        m_prev_ras = dram_ras_n;
        m_prev_cas = dram_cas_n;
    end

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // bench-side state
    bit in_txn = 1'b0;
    bit cur_we = 1'b0;
    bit page_open = 1'b0;
    bit refreshed = 1'b0;
    int open_row = 0;
    int txn_ras = 0;
    int txn_cas = 0;
    int exp_ref_row = 0;
    int ref_count = 0;
    longint cyc = 0;
    longint last_ref = -1;
    bit mon_prev_ras = 1'b1;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_prev_ras && !dram_ras_n) begin
                if (in_txn) begin
                    txn_ras++;
                end else begin
                    chk(int'(dram_addr[ROW_W-1:0]) == exp_ref_row, "R8", "refresh row",
                        dram_addr[ROW_W-1:0], exp_ref_row);
                    chk(dram_cas_n == 1'b1, "R9", "cas during refresh", dram_cas_n, 1);
                    if (last_ref >= 0) begin
                        chk((cyc - last_ref >= REF_CYC - 12) && (cyc - last_ref <= REF_CYC + 12),
                            "R7", "refresh gap", cyc - last_ref, REF_CYC);
                    end
                    last_ref = cyc;
                    exp_ref_row = (exp_ref_row + 1) % (1 << ROW_W);
                    ref_count++;
                    page_open = 1'b0;
                    refreshed = 1'b1;
                end
            end
            if (!dram_cas_n) begin
                if (in_txn) begin
                    txn_cas++;
                    chk(dram_we_n == !cur_we && dram_dq_oe == cur_we, "R6", "we_n/oe in column",
                        {dram_we_n, dram_dq_oe}, {!cur_we, cur_we});
                end else begin
                    chk(1'b0, "R9", "column strobe outside access", 0, 1);
                end
            end
            mon_prev_ras = dram_ras_n;
        end
    end

    task automatic access(input bit we, input int addr, input logic [DATA_W-1:0] wd);
        int row = addr >> COL_W;
        bit hit, closed;
        int exp_lat, exp_ras, lat;
        string tag;
        @(posedge clk); #2;
        req_valid = 1'b1; req_we = we; req_addr = AW'(addr); req_wdata = wd;
        while (!req_ready) begin @(posedge clk); #2; end
        hit = page_open && (row == open_row);
        closed = !page_open;
        exp_lat = hit ? T_CAS : (closed ? T_RCD + T_CAS : T_PRE + T_RCD + T_CAS);
        exp_ras = hit ? 0 : 1;
        tag = hit ? "R3" : (closed ? (refreshed ? "R10" : "R2") : "R4");
        in_txn = 1'b1; cur_we = we; txn_ras = 0; txn_cas = 0;
        lat = 0;
        @(posedge clk); #2;
        req_valid = 1'b0;
        while (!rsp_valid && lat < 60) begin
            lat++;
            @(posedge clk); #2;
        end
        chk(lat == exp_lat, tag, "latency", lat, exp_lat);
        chk(txn_ras == exp_ras, tag, "row strobe falls", txn_ras, exp_ras);
        chk(txn_cas == T_CAS, "R5", "column strobe width", txn_cas, T_CAS);
        if (we) shadow[addr] = wd;
        else chk(rsp_rdata == shadow[addr], "R6", "read data", rsp_rdata, shadow[addr]);
        in_txn = 1'b0;
        page_open = 1'b1; open_row = row; refreshed = 1'b0;
        @(posedge clk); #2;
        chk(rsp_valid == 1'b0, "R5", "rsp pulse length", rsp_valid, 0);
    endtask

    function automatic int pick_addr();
        int row = ($urandom % 4 == 0) ? int'($urandom % (1 << ROW_W)) : int'($urandom % 3);
        return (row << COL_W) | int'($urandom % (1 << COL_W));
    endfunction

    initial begin
        for (int i = 0; i < WORDS; i++) begin dmem[i] = '0; shadow[i] = '0; end
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        chk(dram_ras_n == 1 && dram_cas_n == 1, "R1", "strobes in reset", {dram_ras_n, dram_cas_n}, 3);
        chk(rsp_valid == 0, "R1", "rsp in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);
        // directed: closed, hit, miss, refresh-closed page
        access(1'b1, (1 << COL_W) | 3, 16'hA5A5);
        access(1'b0, (1 << COL_W) | 3, 16'h0);
        access(1'b1, (2 << COL_W) | 7, 16'h1234);
        access(1'b0, (1 << COL_W) | 3, 16'h0);
        repeat (REF_CYC + 20) @(posedge clk);
        access(1'b0, (1 << COL_W) | 3, 16'h0);
        // random mix
        for (int n = 0; n < 1500; n++) begin
            int gap = int'($urandom % 4);
            repeat (gap) @(posedge clk);
            access(1'($urandom % 2), pick_addr(), DATA_W'($urandom));
        end
        chk(ref_count >= int'(cyc / REF_CYC) - 2, "R7", "refresh count", ref_count, cyc / REF_CYC);
        chk(ref_count > (1 << ROW_W), "R8", "row counter wrapped", ref_count, (1 << ROW_W) + 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule